// File: doc/BRIEF.md
# AXI4-Lite Input Register Bank with Selectable Readback

This block is an AXI4-Lite slave that holds the configuration words feeding a piece of user logic. It has two kinds of word. A scalar word reaches its output as soon as it is written. A vector word is written into a shadow copy first. A single commit write then moves every shadowed element onto the outputs in the same clock cycle, so the user logic never sees a half-updated vector.

Software can also read back the values it wrote. Whether a word can be read back is set when the block is built. One global switch sets the default, and each word can override it with on, off, or follow-the-global. Words whose readback is disabled read as zero.

The read path is an OR-tree multiplexer over all words. It can be split into groups of a parameterised size, with one register stage behind each group. This shortens the combinational path at the cost of one extra cycle of read latency.

Top module: `rbk_regbank`

Address map, with byte offsets:
- Scalar word i sits at `4*i`.
- Vector element j sits at `0x100 + 4*j`.
- The commit word sits at `0x110`.
- Any other address, including any address that is not word-aligned, is unmapped.

Word index p numbers the scalars first (0 to NS-1), then the vector elements (NS to NS+NV-1).

## Requirements
- R1: After reset, every scalar output, vector output and shadow element is zero. A read of any enabled word returns 0x00000000.
- R2: A write to a scalar word updates that word's output on the clock edge that completes the write. A later read of the same address returns the new value when that word's readback is enabled.
- R3: For a write, byte lane b of the data is taken only where WSTRB bit b is 1, and the other bytes keep their old value. This applies to scalar words and to shadow elements. For the commit word, byte lane 0 must be enabled for a commit to happen.
- R4: A write to a vector element changes only its shadow copy. The vector outputs stay unchanged until a commit.
- R5: A write to 0x110 with WSTRB bit 0 set and data bit 0 equal to 1 copies all shadow elements to the vector outputs in one cycle. A write there with data bit 0 equal to 0 changes nothing. A read of 0x110 always returns zero.
- R6: The readback mode of word p is the 2-bit field `RB_MODE[2p+1:2p]`, with 00 = inherit, 01 = on and 10 = off (11 counts as off). Inherit takes the value of `GLOBAL_RB`, which defaults to 0, and every field defaults to inherit. A read of a word with readback off returns zero.
- R7: A write to an unmapped address changes no output and no stored value. A read of an unmapped address returns zero.
- R8: The write address and the write data may be accepted in either order, or in the same cycle. BRESP and RRESP are always 00 (OKAY), and BVALID stays high until BREADY.
- R9: RVALID rises 1+L clock edges after the edge that accepts the read address. L is 1 when `RATIO` is greater than 0 and 0 otherwise. RVALID and RDATA stay unchanged until RREADY is seen.
- R10: Only one read is in flight at a time. ARREADY is low from the acceptance of a read address until its data is accepted.
- R11: When readback is enabled, a read of a vector element's address returns the committed output value, not the shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awaddr | input | AW | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | DW | Write data |
| wstrb | input | DW/8 | Write byte enables |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | AW | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | DW | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| scal_o | output | NS*DW | Scalar outputs, word i at bits [i*DW +: DW] |
| vec_o | output | NV*DW | Committed vector outputs, element j at bits [j*DW +: DW] |

## Verification
A corrupted scalar or shadow word shows up on `scal_o` on the edge after the write, or on `vec_o` right after the next commit. The bench checks both ports after every write, so such a fault is caught within one transaction. A wrong readback enable or a wrong decode shows as a non-zero or missing value in the next sweep of the address space. A fault in the pipeline or handshake shows as a latency that differs from 1+L, or as RDATA changing while RREADY is low, during the read that is in flight.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    typedef enum logic [1:0] {
        RB_INHERIT = 2'b00,
        RB_ON      = 2'b01,
        RB_OFF     = 2'b10
    } rb_mode_e;

    localparam logic [1:0]  RESP_OKAY  = 2'b00;
    localparam logic [31:0] SCAL_BASE  = 32'h0000_0000;
    localparam logic [31:0] VEC_BASE   = 32'h0000_0100;
    localparam logic [31:0] COMMIT_OFF = 32'h0000_0110;

    // Byte offset of word p: scalars first, then vector elements.
    function automatic logic [31:0] port_off(input int p, input int ns);
        if (p < ns)
            return SCAL_BASE + 32'(4 * p);
        return VEC_BASE + 32'(4 * (p - ns));
    endfunction

    // Resolve a per-word readback mode against the global switch.
    function automatic logic rb_resolve(input logic [1:0] mode, input logic glob);
        case (mode)
            RB_ON:      return 1'b1;
            RB_INHERIT: return glob;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rbk_wr_chan.sv
module rbk_wr_chan #(
    parameter int DW = 32,
    parameter int AW = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   awaddr,
    input  logic            awvalid,
    output logic            awready,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] wstrb,
    input  logic            wvalid,
    output logic            wready,
    output logic [1:0]      bresp,
    output logic            bvalid,
    input  logic            bready,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic [DW/8-1:0] wr_strb
);
    import rbk_pkg::*;

    logic aw_full, w_full;

    assign awready = !aw_full && !bvalid;
    assign wready  = !w_full  && !bvalid;
    assign wr_en   = aw_full && w_full;
    assign bresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            bvalid  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_full <= 1'b1;
                wr_addr <= awaddr;
            end
            if (wvalid && wready) begin
                w_full  <= 1'b1;
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
            if (wr_en) begin
                aw_full <= 1'b0;
                w_full  <= 1'b0;
                bvalid  <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rbk_store.sv
module rbk_store #(
    parameter int DW = 32,
    parameter int AW = 12,
    parameter int NS = 2,
    parameter int NV = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW/8-1:0]  wr_strb,
    output logic [NS*DW-1:0] scal_o,
    output logic [NV*DW-1:0] vec_o,
    output logic             commit
);
    import rbk_pkg::*;

    localparam int NB = DW / 8;
    localparam logic [AW-1:0] COMMIT_A = AW'(COMMIT_OFF);

    logic [DW-1:0] scal_q [NS];
    logic [DW-1:0] stg_q  [NV];
    logic [DW-1:0] out_q  [NV];

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                            input logic [DW-1:0] new_v,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r;
        r = old_v;
        for (int b = 0; b < NB; b++)
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        return r;
    endfunction

    assign commit = wr_en && (wr_addr == COMMIT_A) && wr_strb[0] && wr_data[0];

    for (genvar i = 0; i < NS; i++) begin : g_scal
        localparam logic [AW-1:0] MY_A = AW'(port_off(i, NS));
        always_ff @(posedge clk) begin
            if (rst)
                scal_q[i] <= '0;
            else if (wr_en && wr_addr == MY_A)
                scal_q[i] <= merge(scal_q[i], wr_data, wr_strb);
        end
        assign scal_o[i*DW +: DW] = scal_q[i];
    end

    for (genvar j = 0; j < NV; j++) begin : g_vec
        localparam logic [AW-1:0] MY_A = AW'(port_off(NS + j, NS));
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q[j] <= '0;
                out_q[j] <= '0;
            end else begin
                if (wr_en && wr_addr == MY_A)
                    stg_q[j] <= merge(stg_q[j], wr_data, wr_strb);
                if (commit)
                    out_q[j] <= stg_q[j];
            end
        end
        assign vec_o[j*DW +: DW] = out_q[j];
    end

endmodule

// File: rtl/rbk_rd_path.sv
module rbk_rd_path #(
    parameter int DW    = 32,
    parameter int AW    = 12,
    parameter int NS    = 2,
    parameter int NP    = 4,
    parameter int RATIO = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    araddr,
    input  logic             arvalid,
    output logic             arready,
    output logic [DW-1:0]    rdata,
    output logic [1:0]       rresp,
    output logic             rvalid,
    input  logic             rready,
    input  logic [NP*DW-1:0] view,
    input  logic [NP-1:0]    rb_en
);
    import rbk_pkg::*;

    localparam int GS = (RATIO > 0) ? RATIO : NP;
    localparam int NG = (NP + GS - 1) / GS;

    logic          busy, v0, fire;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] pv     [NP];
    logic [DW-1:0] grp_c  [NG];
    logic [DW-1:0] grp_s  [NG];
    logic [DW-1:0] fin;

    assign arready = !busy;
    assign rresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            v0      <= 1'b0;
            rd_addr <= '0;
        end else begin
            v0 <= arvalid && arready;
            if (arvalid && arready) begin
                busy    <= 1'b1;
                rd_addr <= araddr;
            end else if (rvalid && rready) begin
                busy <= 1'b0;
            end
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam logic [AW-1:0] MY_A = AW'(port_off(p, NS));
        assign pv[p] = (rb_en[p] && rd_addr == MY_A) ? view[p*DW +: DW] : '0;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        always_comb begin
            grp_c[g] = '0;
            for (int k = 0; k < NP; k++)
                if (k / GS == g) grp_c[g] = grp_c[g] | pv[k];
        end
    end

    if (RATIO > 0) begin : g_pipe
        logic          v1;
        logic [DW-1:0] grp_q [NG];
        always_ff @(posedge clk) begin
            if (rst) v1 <= 1'b0;
            else     v1 <= v0;
        end
        for (genvar g = 0; g < NG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)     grp_q[g] <= '0;
                else if (v0) grp_q[g] <= grp_c[g];
            end
            assign grp_s[g] = grp_q[g];
        end
        assign fire = v1;
    end else begin : g_comb
        for (genvar g = 0; g < NG; g++) begin : g_pass
            assign grp_s[g] = grp_c[g];
        end
        assign fire = v0;
    end

    always_comb begin
        fin = '0;
        for (int g = 0; g < NG; g++)
            fin = fin | grp_s[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (fire) begin
            rvalid <= 1'b1;
            rdata  <= fin;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/rbk_regbank.sv
module rbk_regbank #(
    parameter int                   DW        = 32,
    parameter int                   AW        = 12,
    parameter int                   NS        = 2,
    parameter int                   NV        = 2,
    parameter int                   RATIO     = 0,
    parameter logic                 GLOBAL_RB = 1'b0,
    parameter logic [2*(NS+NV)-1:0] RB_MODE   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    awaddr,
    input  logic             awvalid,
    output logic             awready,
    input  logic [DW-1:0]    wdata,
    input  logic [DW/8-1:0]  wstrb,
    input  logic             wvalid,
    output logic             wready,
    output logic [1:0]       bresp,
    output logic             bvalid,
    input  logic             bready,
    input  logic [AW-1:0]    araddr,
    input  logic             arvalid,
    output logic             arready,
    output logic [DW-1:0]    rdata,
    output logic [1:0]       rresp,
    output logic             rvalid,
    input  logic             rready,
    output logic [NS*DW-1:0] scal_o,
    output logic [NV*DW-1:0] vec_o
);
    import rbk_pkg::*;

    localparam int NP = NS + NV;

    logic            wr_en, commit_w;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic [DW/8-1:0] wr_strb;
    logic [NP-1:0]   rb_en;

    for (genvar p = 0; p < NP; p++) begin : g_en
        assign rb_en[p] = rb_resolve(RB_MODE[2*p +: 2], GLOBAL_RB);
    end

    rbk_wr_chan #(.DW(DW), .AW(AW)) u_wr (
        .clk(clk), .rst(rst),
        .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    rbk_store #(.DW(DW), .AW(AW), .NS(NS), .NV(NV)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .scal_o(scal_o), .vec_o(vec_o), .commit(commit_w)
    );

    rbk_rd_path #(.DW(DW), .AW(AW), .NS(NS), .NP(NP), .RATIO(RATIO)) u_rd (
        .clk(clk), .rst(rst),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .view({vec_o, scal_o}), .rb_en(rb_en)
    );

endmodule

// File: rtl/rbk_regbank_chk.sv
module rbk_regbank_chk #(
    parameter int DW    = 32,
    parameter int NV    = 2,
    parameter int RATIO = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             arvalid,
    input logic             arready,
    input logic             rvalid,
    input logic             rready,
    input logic [DW-1:0]    rdata,
    input logic [1:0]       rresp,
    input logic             bvalid,
    input logic             bready,
    input logic [1:0]       bresp,
    input logic [NV*DW-1:0] vec_o,
    input logic             commit_w
);
    // Sample distance from the address handshake to the rise of RVALID.
    localparam int DEPTH = (RATIO > 0) ? 3 : 2;

    a_r9_rvalid_hold: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));

    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> $past(arvalid && arready, DEPTH));

    a_r10_single_read: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !arready);

    a_r8_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

    a_r8_bresp_okay: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> bresp == 2'b00);

    a_r8_rresp_okay: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rresp == 2'b00);

    a_r4_vec_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(commit_w) |-> $stable(vec_o));

endmodule

bind rbk_regbank rbk_regbank_chk #(.DW(DW), .NV(NV), .RATIO(RATIO)) u_chk (
    .clk(clk), .rst(rst),
    .arvalid(arvalid), .arready(arready),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .vec_o(vec_o), .commit_w(commit_w)
);

// File: tb/rbk_regbank_bench.sv
module rbk_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int NS = 2;
    localparam int NV = 2;
    localparam int RATIO = 2;
    localparam int EXP_LAT = (RATIO > 0) ? 2 : 1;
    // Words: p0 inherit (global on), p1 off, p2 on, p3 inherit.
    localparam logic [7:0] MODES = 8'b00_01_10_00;
    localparam logic [3:0] EN_B  = 4'b1101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DW-1:0] rdata;
    logic [NS*DW-1:0] scal_o;
    logic [NV*DW-1:0] vec_o;
    logic awready_d, wready_d, bvalid_d, arready_d, rvalid_d;
    logic [1:0] bresp_d, rresp_d;
    logic [DW-1:0] rdata_d;
    logic [NS*DW-1:0] scal_d;
    logic [NV*DW-1:0] vec_d;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int cyc     = 0;

    logic [DW-1:0] m_sc [NS];
    logic [DW-1:0] m_st [NV];
    logic [DW-1:0] m_out[NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    rbk_regbank #(.DW(DW), .AW(AW), .NS(NS), .NV(NV), .RATIO(RATIO),
                  .GLOBAL_RB(1'b1), .RB_MODE(MODES)) u_rbk_regbank (
        .clk(clk), .rst(rst), .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
        .scal_o(scal_o), .vec_o(vec_o));

    // Same bus, default readback configuration.
    rbk_regbank #(.DW(DW), .AW(AW), .NS(NS), .NV(NV), .RATIO(RATIO)) u_rbk_regbank_dflt (
        .clk(clk), .rst(rst), .awaddr(awaddr), .awvalid(awvalid), .awready(awready_d),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready_d),
        .bresp(bresp_d), .bvalid(bvalid_d), .bready(bready),
        .araddr(araddr), .arvalid(arvalid), .arready(arready_d),
        .rdata(rdata_d), .rresp(rresp_d), .rvalid(rvalid_d), .rready(rready),
        .scal_o(scal_d), .vec_o(vec_d));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bmerge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                             input logic [3:0] s);
        logic [DW-1:0] r;
        r = o;
        for (int b = 0; b < 4; b++)
            if (s[b]) r = (r & ~(32'hFF << (8*b))) | (n & (32'hFF << (8*b)));
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        for (int p = 0; p < NS + NV; p++) begin
            int off;
            off = (p < NS) ? 4*p : 'h100 + 4*(p - NS);
            if (a == AW'(off) && EN_B[p])
                return (p < NS) ? m_sc[p] : m_out[p - NS];
        end
        return '0;
    endfunction

    task automatic check_outs(input string req);
        for (int i = 0; i < NS; i++) begin
            chk(req, scal_o[i*DW +: DW], m_sc[i]);
            chk(req, scal_d[i*DW +: DW], m_sc[i]);
        end
        for (int j = 0; j < NV; j++)
            chk(req, vec_o[j*DW +: DW], m_out[j]);
    endtask

    task automatic axw(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [3:0] s, input int ord);
        bit aw_d, w_d;
        aw_d = 0; w_d = 0;
        @(negedge clk);
        if (ord != 1) begin awaddr = a; awvalid = 1'b1; end
        if (ord != 0) begin wdata = d; wstrb = s; wvalid = 1'b1; end
        while (!(aw_d && w_d)) begin
            logic ta, tw;
            ta = awvalid && awready;
            tw = wvalid && wready;
            @(negedge clk);
            if (ta) begin aw_d = 1; awvalid = 1'b0; end
            if (tw) begin w_d = 1; wvalid = 1'b0; end
            if (ord == 0 && aw_d && !w_d && !wvalid) begin
                wdata = d; wstrb = s; wvalid = 1'b1;
            end
            if (ord == 1 && w_d && !aw_d && !awvalid) begin
                awaddr = a; awvalid = 1'b1;
            end
        end
        while (!bvalid) @(negedge clk);
        chk("R8 bresp okay", {30'd0, bresp}, 32'd0);
        // R8: response held while BREADY is low
        @(negedge clk);
        chk("R8 bvalid held", {31'd0, bvalid}, 32'd1);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        // bench model of the write
        for (int i = 0; i < NS; i++)
            if (a == AW'(4*i)) m_sc[i] = bmerge(m_sc[i], d, s);
        for (int j = 0; j < NV; j++)
            if (a == AW'('h100 + 4*j)) m_st[j] = bmerge(m_st[j], d, s);
        if (a == AW'('h110) && s[0] && d[0])
            for (int j = 0; j < NV; j++) m_out[j] = m_st[j];
    endtask

    task automatic axr(input logic [AW-1:0] a, input int hold, input string req);
        int cnt;
        logic [DW-1:0] got;
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        cnt = 0;
        while (!rvalid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk("R9 read latency", cnt, EXP_LAT);
        chk("R10 arready low while pending", {31'd0, arready}, 32'd0);
        chk("R8 rresp okay", {30'd0, rresp}, 32'd0);
        got = rdata;
        chk(req, got, exp_read(a));
        chk("R6 default readback off", rdata_d, 32'd0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9 rvalid held", {31'd0, rvalid}, 32'd1);
            chk("R9 rdata stable", rdata, got);
            chk("R10 arready low while held", {31'd0, arready}, 32'd0);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 'h120; a += 4) axr(AW'(a), 0, req);
        axr(AW'('h002), 0, "R7 unaligned read");
        axr(AW'('h7FC), 0, "R7 far unmapped read");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1;
                n_fail++;
                n_tests++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) m_sc[i] = '0;
        for (int j = 0; j < NV; j++) begin m_st[j] = '0; m_out[j] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        check_outs("R1 reset outputs");
        sweep("R1 read after reset");

        // R2 / R8: scalar writes in every handshake order
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < NS; i++) begin
                axw(AW'(4*i), 32'h0101_0101 * (8*r + i + 1) + r, 4'hF, (r + i) % 3);
                check_outs("R2 scalar output");
                axr(AW'(4*i), 0, "R2 R6 scalar readback");
            end
        sweep("R6 readback sweep");

        // R3: every byte-enable pattern on a scalar and a shadow element
        for (int s = 0; s < 16; s++) begin
            axw(AW'(0), 32'hA5C3_0000 + 32'h1111 * s, 4'(s), s % 3);
            check_outs("R3 scalar byte enables");
            axw(AW'('h104), 32'h5A00_3C00 + 32'h0101 * s, 4'(s), (s + 1) % 3);
            axw(AW'('h110), 32'h1, 4'hF, 2);
            check_outs("R3 shadow byte enables");
        end

        // R4 / R5 / R11: staging and commit
        for (int r = 0; r < 3; r++) begin
            axw(AW'('h100), 32'hC0DE_0000 + r, 4'hF, r % 3);
            axw(AW'('h104), 32'hBEEF_0000 + 7*r, 4'hF, (r + 2) % 3);
            check_outs("R4 vector held before commit");
            axr(AW'('h100), 0, "R11 readback of committed value");
            axw(AW'('h110), 32'h0, 4'hF, 0);
            check_outs("R5 commit with bit0 clear");
            axw(AW'('h110), 32'h1, 4'hE, 1);
            check_outs("R3 R5 commit with lane0 disabled");
            axw(AW'('h110), 32'h1, 4'hF, 2);
            chk("R5 element 0 committed", vec_o[0 +: DW], 32'hC0DE_0000 + r);
            chk("R5 element 1 committed", vec_o[DW +: DW], 32'hBEEF_0000 + 7*r);
            axr(AW'('h100), 0, "R11 element 0 readback");
            axr(AW'('h104), 0, "R11 element 1 readback");
            axr(AW'('h110), 0, "R5 commit word reads zero");
        end

        // R7: unmapped writes are ignored
        axw(AW'('h008), 32'hDEAD_0001, 4'hF, 0);
        axw(AW'('h108), 32'hDEAD_0002, 4'hF, 1);
        axw(AW'('h200), 32'hDEAD_0003, 4'hF, 2);
        axw(AW'('h102), 32'hDEAD_0004, 4'hF, 0);
        axw(AW'('h110), 32'h1, 4'hF, 1);
        check_outs("R7 unmapped writes ignored");
        sweep("R7 R6 sweep after unmapped writes");

        // R9 / R10: held read data
        axr(AW'(0), 3, "R9 held scalar read");
        axr(AW'('h104), 4, "R9 held vector read");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule